// File: doc/BRIEF.md
# Adaptive Dual-Output Logic Cell

This cell models one slice of a programmable logic fabric. An eight-input combinational block holds a 64-bit truth table. A static mode word divides the table into two lookup functions of different sizes, and sets which of the eight inputs each function sees and which inputs the two share. Each of the two results can pass through a dedicated full adder. The two adders form a ripple carry from a carry input to a carry output. The two registers either capture the two results or form a two-stage shift path. That path takes a serial input from the cell before it and hands a serial output to the cell after it.

The mode, the table, the arithmetic enable and the chain select are configuration. They are meant to stay constant during normal operation. The bench also changes them from cycle to cycle, and the cell must then respond to the new values within the same cycle. An encoding outside the legal set forces both results to zero and raises an error flag.

Top module: `adaptive_logic_cell`

## Requirements
- R1: Mode 3'd0 gives two independent 4-input functions. Output 0 is `table_bits[lut_in[3:0]]` and output 1 is `table_bits[16 + lut_in[7:4]]`.
- R2: Mode 3'd1 gives a 5-input and a 3-input function on disjoint inputs. Output 0 is `table_bits[lut_in[4:0]]` and output 1 is `table_bits[32 + lut_in[7:5]]`.
- R3: Mode 3'd2 gives a 5-input and a 4-input function that share `lut_in[0]`. Output 0 is `table_bits[lut_in[4:0]]` and output 1 is `table_bits[32 + 2*lut_in[7:5] + lut_in[0]]`.
- R4: Mode 3'd3 gives two 5-input functions that share `lut_in[1:0]`. Output 0 is `table_bits[lut_in[4:0]]` and output 1 is `table_bits[32 + 4*lut_in[7:5] + lut_in[1:0]]`.
- R5: Mode 3'd4 gives one 6-input function. Output 0 is `table_bits[lut_in[5:0]]` and output 1 is 0.
- R6: Mode 3'd5 gives two copies of one 6-input table that share `lut_in[3:0]`. Output 0 is `table_bits[lut_in[5:0]]` and output 1 is `table_bits[16*lut_in[7:6] + lut_in[3:0]]`.
- R7: Modes 3'd6 and 3'd7 are illegal. In these modes `comb_out` is 0, `carry_out` is 0 and `mode_err` is 1. In every legal mode `mode_err` is 0.
- R8: With `arith_en` set, adder 0 adds function 0, `add_b[0]` and `carry_in`. Adder 1 adds function 1, `add_b[1]` and the carry from adder 0. The two sums appear on `comb_out[0]` and `comb_out[1]`, and the carry from adder 1 drives `carry_out`. With `arith_en` clear, `comb_out` carries the function values and `carry_out` is 0.
- R9: With `chain_sel` clear, `reg_out` takes the value `comb_out` had at the previous rising clock edge. While `rst_n` is low, `reg_out` and `chain_out` are 0.
- R10: With `chain_sel` set, `reg_out[0]` takes `chain_in` at each rising edge and `reg_out[1]` takes the old `reg_out[0]`. `chain_out` always equals `reg_out[1]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the two registers |
| mode | input | 3 | Static partition mode |
| arith_en | input | 1 | Route both functions through the full adders |
| chain_sel | input | 1 | Registers form a shift chain instead of capturing results |
| table_bits | input | 64 | Truth table contents |
| lut_in | input | 8 | Function inputs |
| add_b | input | 2 | Second addend of each adder |
| carry_in | input | 1 | Carry into adder 0 |
| chain_in | input | 1 | Serial input from the preceding cell |
| comb_out | output | 2 | Combinational results |
| reg_out | output | 2 | Register outputs |
| carry_out | output | 1 | Carry out of adder 1 |
| chain_out | output | 1 | Serial output to the following cell |
| mode_err | output | 1 | Illegal mode flag |

## Verification
Several rules hold on every cycle, and the assertions check them continuously. An illegal mode clears every result and raises the error flag, and a legal mode never raises it. Outside arithmetic, the single 6-input mode holds its second output at zero. In the twin 6-input mode, both outputs agree whenever the two private input pairs are equal. The registers either capture the previous results or shift the chain by one place. Whether the right table bit is selected for each mode and input pattern, and whether the sums and carries are correct, can only be shown by the bench. It compares each result with an independent model over random tables and inputs, and adds directed carry cases.

// File: rtl/adaptive_logic_cell.sv
module adaptive_logic_cell (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  mode,
  input  logic        arith_en,
  input  logic        chain_sel,
  input  logic [63:0] table_bits,
  input  logic [7:0]  lut_in,
  input  logic [1:0]  add_b,
  input  logic        carry_in,
  input  logic        chain_in,
  output logic [1:0]  comb_out,
  output logic [1:0]  reg_out,
  output logic        carry_out,
  output logic        chain_out,
  output logic        mode_err
);

  logic fn0, fn1, illegal;
  logic c_mid, c_end, s0, s1;
  logic [1:0] result;

  always_comb begin
    fn0 = 1'b0;
    fn1 = 1'b0;
    illegal = 1'b0;
    case (mode)
      3'd0: begin
        fn0 = table_bits[{2'b00, lut_in[3:0]}];
        fn1 = table_bits[{2'b01, lut_in[7:4]}];
      end
      3'd1: begin
        fn0 = table_bits[{1'b0, lut_in[4:0]}];
        fn1 = table_bits[{3'b100, lut_in[7:5]}];
      end
      3'd2: begin
        fn0 = table_bits[{1'b0, lut_in[4:0]}];
        fn1 = table_bits[{2'b10, lut_in[7:5], lut_in[0]}];
      end
      3'd3: begin
        fn0 = table_bits[{1'b0, lut_in[4:0]}];
        fn1 = table_bits[{1'b1, lut_in[7:5], lut_in[1:0]}];
      end
      3'd4: fn0 = table_bits[lut_in[5:0]];
      3'd5: begin
        fn0 = table_bits[lut_in[5:0]];
        fn1 = table_bits[{lut_in[7:6], lut_in[3:0]}];
      end
      default: illegal = 1'b1;
    endcase
  end

  assign s0    = fn0 ^ add_b[0] ^ carry_in;
  assign c_mid = (fn0 & add_b[0]) | (fn0 & carry_in) | (add_b[0] & carry_in);
  assign s1    = fn1 ^ add_b[1] ^ c_mid;
  assign c_end = (fn1 & add_b[1]) | (fn1 & c_mid) | (add_b[1] & c_mid);

  assign result    = illegal ? 2'b00 : (arith_en ? {s1, s0} : {fn1, fn0});
  assign carry_out = arith_en & ~illegal & c_end;
  assign comb_out  = result;
  assign mode_err  = illegal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      reg_out <= 2'b00;
    else if (chain_sel)
      reg_out <= {reg_out[0], chain_in};
    else
      reg_out <= result;
  end

  assign chain_out = reg_out[1];

endmodule

// File: rtl/adaptive_logic_cell_chk.sv
module adaptive_logic_cell_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] mode,
  input logic       arith_en,
  input logic       chain_sel,
  input logic [7:0] lut_in,
  input logic       chain_in,
  input logic [1:0] comb_out,
  input logic [1:0] reg_out,
  input logic       carry_out,
  input logic       mode_err
);

  logic armed;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;

  // R7
  illegal_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode[2:1] == 2'b11 |-> comb_out == 2'b00 && !carry_out && mode_err);

  // R7
  legal_noerr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode[2:1] != 2'b11 |-> !mode_err);

  // R5
  single_six_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 3'd4 && !arith_en |-> comb_out[1] == 1'b0);

  // R6
  twin_six_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 3'd5 && !arith_en && lut_in[7:6] == lut_in[5:4] |-> comb_out[0] == comb_out[1]);

  // R8
  no_arith_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !arith_en |-> !carry_out);

  // R9
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !chain_sel |=> reg_out == $past(comb_out));

  // R10
  shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && chain_sel |=> reg_out == {$past(reg_out[0]), $past(chain_in)});

endmodule

bind adaptive_logic_cell adaptive_logic_cell_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .arith_en(arith_en),
  .chain_sel(chain_sel), .lut_in(lut_in), .chain_in(chain_in),
  .comb_out(comb_out), .reg_out(reg_out), .carry_out(carry_out),
  .mode_err(mode_err)
);

// File: tb/test_adaptive_logic_cell.sv
module test_adaptive_logic_cell;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  mode = 3'd0;
  logic        arith_en = 1'b0, chain_sel = 1'b0, carry_in = 1'b0, chain_in = 1'b0;
  logic [63:0] table_bits = '0;
  logic [7:0]  lut_in = '0;
  logic [1:0]  add_b = '0;
  logic [1:0]  comb_out, reg_out;
  logic        carry_out, chain_out, mode_err;

  int total = 0, bad = 0;
  logic [1:0] q_exp = 2'b00;

  always #4 clk = ~clk;

  adaptive_logic_cell i_adaptive_logic_cell (
    .clk(clk), .rst_n(rst_n), .mode(mode), .arith_en(arith_en),
    .chain_sel(chain_sel), .table_bits(table_bits), .lut_in(lut_in),
    .add_b(add_b), .carry_in(carry_in), .chain_in(chain_in),
    .comb_out(comb_out), .reg_out(reg_out), .carry_out(carry_out),
    .chain_out(chain_out), .mode_err(mode_err)
  );

  function automatic logic [3:0] model(input logic [2:0] m, input logic ar,
      input logic [63:0] tb, input logic [7:0] d, input logic [1:0] b, input logic ci);
    int i0, i1;
    logic f0, f1, c0, c1, s0, s1;
    if (m >= 3'd6) return 4'b1000;
    i0 = (m == 3'd0) ? int'(d[3:0]) : (m >= 3'd4) ? int'(d[5:0]) : int'(d[4:0]);
    case (m)
      3'd0: i1 = 16 + d[7:4];
      3'd1: i1 = 32 + d[7:5];
      3'd2: i1 = 32 + 2 * d[7:5] + d[0];
      3'd3: i1 = 32 + 4 * d[7:5] + d[1:0];
      3'd5: i1 = 16 * d[7:6] + d[3:0];
      default: i1 = -1;
    endcase
    f0 = tb[i0];
    f1 = (i1 < 0) ? 1'b0 : tb[i1];
    if (!ar) return {2'b00, f1, f0};
    s0 = f0 ^ b[0] ^ ci;
    c0 = (f0 & b[0]) | (f0 & ci) | (b[0] & ci);
    s1 = f1 ^ b[1] ^ c0;
    c1 = (f1 & b[1]) | (f1 & c0) | (b[1] & c0);
    return {1'b0, c1, s1, s0};
  endfunction

  function automatic string tag_of(input logic [2:0] m, input logic ar);
    if (m >= 3'd6) return "R7";
    if (ar) return "R8";
    case (m)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp_v);
    total++;
    if (act !== exp_v) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp_v, $time);
    end
  endtask

  task automatic step(input logic [2:0] m, input logic ar, input logic ch,
      input logic [63:0] tb, input logic [7:0] d, input logic [1:0] b,
      input logic ci, input logic chi);
    logic [3:0] e;
    @(negedge clk);
    mode = m; arith_en = ar; chain_sel = ch; table_bits = tb;
    lut_in = d; add_b = b; carry_in = ci; chain_in = chi;
    #1;
    e = model(m, ar, tb, d, b, ci);
    check(tag_of(m, ar), {mode_err, carry_out, comb_out}, e);
    @(posedge clk);
    #1;
    q_exp = ch ? {q_exp[0], chi} : e[1:0];
    check(ch ? "R10" : "R9", {2'b00, reg_out}, {2'b00, q_exp});
    check("R10", {3'b000, chain_out}, {3'b000, q_exp[1]});
  endtask

  initial begin
    #(8 * 200000);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    // R9 reset state
    check("R9", {2'b00, reg_out}, 4'b0000);
    check("R10", {3'b000, chain_out}, 4'b0000);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 independent halves
    step(3'd0, 1'b0, 1'b0, 64'h0000_0000_8000_0001, 8'hF0, 2'b00, 1'b0, 1'b0);
    // R3 shared bit selects odd entry
    step(3'd2, 1'b0, 1'b0, 64'h0000_AAAA_0000_0000, 8'h01, 2'b00, 1'b0, 1'b0);
    // R5 full table, second output quiet
    step(3'd4, 1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF, 2'b00, 1'b0, 1'b0);
    // R8 full carry ripple
    step(3'd5, 1'b1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 8'h00, 2'b11, 1'b1, 1'b0);
    step(3'd5, 1'b1, 1'b0, 64'h0000_0000_0000_0000, 8'h00, 2'b01, 1'b1, 1'b0);
    // R7 illegal encodings with arithmetic on
    step(3'd6, 1'b1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF, 2'b11, 1'b1, 1'b0);
    step(3'd7, 1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF, 2'b11, 1'b1, 1'b0);
    // R10 chain shifting
    step(3'd0, 1'b0, 1'b1, 64'h0, 8'h00, 2'b00, 1'b0, 1'b1);
    step(3'd0, 1'b0, 1'b1, 64'h0, 8'h00, 2'b00, 1'b0, 1'b0);
    step(3'd0, 1'b0, 1'b1, 64'h0, 8'h00, 2'b00, 1'b0, 1'b1);

    for (int n = 0; n < 600; n++) begin
      step(3'($urandom_range(0, 7)), 1'($urandom), 1'($urandom_range(0, 3) == 0),
           {$urandom, $urandom}, 8'($urandom), 2'($urandom), 1'($urandom), 1'($urandom));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule